// File: doc/BRIEF.md
# 64B/66B Clock-Correction Elastic Buffer

This block sits on the receive path after block alignment. It carries 66-bit blocks from the recovered write clock to the local read clock. Each block has a 2-bit sync header in bits [65:64] and a 64-bit payload in bits [63:0]. A 64-entry dual-clock FIFO takes up the small rate difference between the two clocks. The read side drops or repeats one designated idle block whenever the occupancy drifts outside a window. The pointers cross between the clocks in Gray code through two-flop synchronizers. Each side works out its own view of occupancy from its own pointer and the synchronized pointer of the other side.

The read side is a three-state machine. PRIME holds output off after reset. The transition PRIME→STREAM fires when occupancy first reaches 40, the midpoint of the 32/48 window. In STREAM the block emits one block per read cycle. It can also delete a correction block, or take the transition STREAM→REPEAT to insert one. REPEAT emits the held correction block a second time and always returns by REPEAT→STREAM. Overflow and underflow are reported as sticky flags that only reset clears.

Top module: `cc_elastic_buf`

## Requirements
- R1: A correction block is exactly header 2'b01 in bits [65:64] with payload 64'h5555_0000_0000_0000, all 66 bits compared. A block with header 2'b10 and the same payload is ordinary data and never triggers a deletion or insertion.
- R2: After read-side reset, `out_valid` stays 0 until the read-side occupancy first reaches 40 entries.
- R3: Outside corrections, each read cycle with a non-empty FIFO outputs the next written block in write order, with `out_valid` high.
- R4: If occupancy is above 48, the head block is a correction block and the head address is odd, that block is skipped. The following block is output in the same cycle with `del_flag` high for that one cycle.
- R5: If occupancy is below 32 and the head block is a correction block, it is output twice in consecutive cycles, with `ins_flag` high only alongside the second copy.
- R6: A write attempted while the write side sees 64 entries is dropped and sets `ovf_flag`, which stays set until write reset.
- R7: A read cycle in STREAM with an empty FIFO outputs nothing (`out_valid` 0) and sets `unf_flag`, which stays set until read reset.
- R8: Reset clears `out_valid`, `out_block`, `ins_flag`, `del_flag`, `unf_flag` (read reset) and `ovf_flag` (write reset).
- R9: `ins_flag` and `del_flag` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Recovered write clock |
| wr_rst_n | input | 1 | Write-domain asynchronous reset, active low |
| in_valid | input | 1 | Aligned input block present |
| in_block | input | 66 | Header [65:64], payload [63:0] |
| ovf_flag | output | 1 | Sticky overflow, write domain |
| rd_clk | input | 1 | Local read clock |
| rd_rst_n | input | 1 | Read-domain asynchronous reset, active low |
| out_valid | output | 1 | Output block present |
| out_block | output | 66 | Output block |
| ins_flag | output | 1 | One-cycle pulse with a repeated correction block |
| del_flag | output | 1 | One-cycle pulse when a correction block was skipped |
| unf_flag | output | 1 | Sticky underflow, read domain |

## Verification
A corrupted read pointer or a wrong state shows up at the outputs on the very next read cycle. The block that comes out is then out of order, a copy that is not a correction block, or a correction block that is missing. Each of these differs from the bench's record of the written stream. A wrong occupancy view shows up within one correction spacing, as an insertion or deletion the phase does not allow, or as one that never appears. A state machine stuck in PRIME leaves `out_valid` low long after 40 blocks have been written.

// File: rtl/cceb_pkg.sv
package cceb_pkg;

    localparam int BLK_W = 66;

    typedef logic [BLK_W-1:0] blk_t;

    // Header 01 in [65:64], idle pattern in the payload.
    localparam blk_t CC_BLK = {2'b01, 64'h5555_0000_0000_0000};

    typedef enum logic [1:0] {
        RS_PRIME  = 2'd0,
        RS_STREAM = 2'd1,
        RS_REPEAT = 2'd2
    } rd_state_e;

endpackage

// File: rtl/cceb_sync.sv
module cceb_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q_sync <= '0;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end
endmodule

// File: rtl/cceb_gray2bin.sv
module cceb_gray2bin #(
    parameter int W = 7
) (
    input  logic [W-1:0] gray,
    output logic [W-1:0] bin
);
    assign bin[W-1] = gray[W-1];
    for (genvar i = W - 2; i >= 0; i--) begin : g_bit
        assign bin[i] = bin[i+1] ^ gray[i];
    end
endmodule

// File: rtl/cceb_wr_side.sv
module cceb_wr_side #(
    parameter int AW    = 6,
    parameter int DEPTH = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [AW:0]   rd_gray_async,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [AW:0]   wr_gray,
    output logic          ovf_flag
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);

    logic [PW-1:0] wr_ptr_q, wr_ptr_d;
    logic [PW-1:0] rd_gray_s, rd_bin_s, occ_w;
    logic          full;

    cceb_sync #(.W(PW)) u_rsync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (rd_gray_async),
        .q_sync  (rd_gray_s)
    );

    cceb_gray2bin #(.W(PW)) u_rconv (
        .gray (rd_gray_s),
        .bin  (rd_bin_s)
    );

    assign occ_w    = wr_ptr_q - rd_bin_s;
    assign full     = (occ_w >= FULL_LVL);
    assign wr_en    = in_valid && !full;
    assign wr_addr  = wr_ptr_q[AW-1:0];
    assign wr_ptr_d = wr_en ? wr_ptr_q + PW'(1) : wr_ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            wr_gray  <= '0;
            ovf_flag <= 1'b0;
        end else begin
            wr_ptr_q <= wr_ptr_d;
            wr_gray  <= wr_ptr_d ^ (wr_ptr_d >> 1);
            if (in_valid && full) begin
                ovf_flag <= 1'b1;
            end
        end
    end

    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

    p_ovf_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $past(in_valid));
endmodule

// File: rtl/cceb_rd_side.sv
module cceb_rd_side
    import cceb_pkg::*;
#(
    parameter int AW       = 6,
    parameter int LO_MARK  = 32,
    parameter int HI_MARK  = 48,
    parameter int MID_MARK = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW:0]   wr_gray_async,
    input  blk_t          head_blk,
    input  blk_t          next_blk,
    output logic [AW-1:0] rd_addr,
    output logic [AW:0]   rd_gray,
    output logic          out_valid,
    output blk_t          out_block,
    output logic          ins_flag,
    output logic          del_flag,
    output logic          unf_flag
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] LO_P  = PW'(LO_MARK);
    localparam logic [PW-1:0] HI_P  = PW'(HI_MARK);
    localparam logic [PW-1:0] MID_P = PW'(MID_MARK);

    rd_state_e     state_q, state_d;
    logic [PW-1:0] rd_ptr_q, rd_ptr_d;
    logic [PW-1:0] wr_gray_s, wr_bin_s, occ_r;
    logic          head_cc;
    logic          valid_d, ins_d, del_d, unf_d;
    blk_t          blk_d;

    cceb_sync #(.W(PW)) u_wsync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (wr_gray_async),
        .q_sync  (wr_gray_s)
    );

    cceb_gray2bin #(.W(PW)) u_wconv (
        .gray (wr_gray_s),
        .bin  (wr_bin_s)
    );

    assign occ_r   = wr_bin_s - rd_ptr_q;
    assign head_cc = (head_blk == CC_BLK);
    assign rd_addr = rd_ptr_q[AW-1:0];

    // Next state and next outputs
    always_comb begin
        state_d  = state_q;
        rd_ptr_d = rd_ptr_q;
        valid_d  = 1'b0;
        blk_d    = out_block;
        ins_d    = 1'b0;
        del_d    = 1'b0;
        unf_d    = unf_flag;
        unique case (state_q)
            RS_PRIME: begin
                if (occ_r >= MID_P) begin
                    state_d = RS_STREAM;
                end
            end
            RS_STREAM: begin
                if (occ_r == '0) begin
                    unf_d = 1'b1;
                end else if (head_cc && (occ_r > HI_P) && rd_ptr_q[0]) begin
                    // Odd base keeps the +2 Gray step safe for the writer.
                    blk_d    = next_blk;
                    valid_d  = 1'b1;
                    del_d    = 1'b1;
                    rd_ptr_d = rd_ptr_q + PW'(2);
                end else if (head_cc && (occ_r < LO_P)) begin
                    blk_d   = head_blk;
                    valid_d = 1'b1;
                    state_d = RS_REPEAT;
                end else begin
                    blk_d    = head_blk;
                    valid_d  = 1'b1;
                    rd_ptr_d = rd_ptr_q + PW'(1);
                end
            end
            RS_REPEAT: begin
                blk_d    = head_blk;
                valid_d  = 1'b1;
                ins_d    = 1'b1;
                rd_ptr_d = rd_ptr_q + PW'(1);
                state_d  = RS_STREAM;
            end
            default: begin
                state_d = RS_PRIME;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_PRIME;
        end else begin
            state_q <= state_d;
        end
    end

    // Output and pointer registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr_q  <= '0;
            rd_gray   <= '0;
            out_valid <= 1'b0;
            out_block <= '0;
            ins_flag  <= 1'b0;
            del_flag  <= 1'b0;
            unf_flag  <= 1'b0;
        end else begin
            rd_ptr_q  <= rd_ptr_d;
            rd_gray   <= rd_ptr_d ^ (rd_ptr_d >> 1);
            out_valid <= valid_d;
            out_block <= blk_d;
            ins_flag  <= ins_d;
            del_flag  <= del_d;
            unf_flag  <= unf_d;
        end
    end

    p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ins_flag && del_flag));

    p_ins_repeat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ins_flag |-> (out_valid && $past(out_valid) && $stable(out_block)
                      && out_block == CC_BLK));

    p_del_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        del_flag |-> out_valid);

    p_unf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        unf_flag |=> unf_flag);
endmodule

// File: rtl/cc_elastic_buf.sv
module cc_elastic_buf
    import cceb_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int LO_MARK = 32,
    parameter int HI_MARK = 48
) (
    input  logic        wr_clk,
    input  logic        wr_rst_n,
    input  logic        in_valid,
    input  logic [65:0] in_block,
    output logic        ovf_flag,
    input  logic        rd_clk,
    input  logic        rd_rst_n,
    output logic        out_valid,
    output logic [65:0] out_block,
    output logic        ins_flag,
    output logic        del_flag,
    output logic        unf_flag
);
    localparam int AW       = $clog2(DEPTH);
    localparam int PW       = AW + 1;
    localparam int MID_MARK = (LO_MARK + HI_MARK) / 2;

    blk_t          mem [DEPTH];
    logic          wr_en;
    logic [AW-1:0] wr_addr, rd_addr, nxt_addr;
    logic [PW-1:0] wr_gray, rd_gray;
    blk_t          head_blk, next_blk;

    cceb_wr_side #(.AW(AW), .DEPTH(DEPTH)) u_wr (
        .clk           (wr_clk),
        .rst_n         (wr_rst_n),
        .in_valid      (in_valid),
        .rd_gray_async (rd_gray),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_gray       (wr_gray),
        .ovf_flag      (ovf_flag)
    );

    always_ff @(posedge wr_clk) begin
        if (wr_en) begin
            mem[wr_addr] <= in_block;
        end
    end

    assign nxt_addr = rd_addr + AW'(1);
    assign head_blk = mem[rd_addr];
    assign next_blk = mem[nxt_addr];

    cceb_rd_side #(
        .AW       (AW),
        .LO_MARK  (LO_MARK),
        .HI_MARK  (HI_MARK),
        .MID_MARK (MID_MARK)
    ) u_rd (
        .clk           (rd_clk),
        .rst_n         (rd_rst_n),
        .wr_gray_async (wr_gray),
        .head_blk      (head_blk),
        .next_blk      (next_blk),
        .rd_addr       (rd_addr),
        .rd_gray       (rd_gray),
        .out_valid     (out_valid),
        .out_block     (out_block),
        .ins_flag      (ins_flag),
        .del_flag      (del_flag),
        .unf_flag      (unf_flag)
    );
endmodule

// File: tb/tb_cc_elastic_buf.sv
`timescale 1ns/1ps
module tb_cc_elastic_buf;
    localparam logic [65:0] CC  = {2'b01, 64'h5555_0000_0000_0000};
    localparam logic [65:0] BAD = {2'b10, 64'h5555_0000_0000_0000};

    // Phase table: read period ns, blocks, correction spacing,
    // insert expectation, delete expectation (0 none, 1 some, 2 either)
    localparam int NPH = 4;
    localparam int PH [NPH][5] = '{
        '{20,  60, 0, 0, 0},
        '{18, 300, 3, 1, 0},
        '{22, 400, 3, 2, 1},
        '{20, 120, 3, 2, 2}
    };

    logic        wr_clk = 1'b0, rd_clk = 1'b0;
    logic        wr_rst_n = 1'b0, rd_rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [65:0] in_block = '0;
    logic        ovf_flag, out_valid, ins_flag, del_flag, unf_flag;
    logic [65:0] out_block;

    int rd_half = 10;
    int n_tests = 0, n_fail = 0;
    int wcnt = 0, head = 0;
    int n_ins = 0, n_del = 0, n_valid = 0;
    bit chk_en = 1'b0;
    logic [65:0] q [0:4095];
    logic [65:0] last_out = '0;

    cc_elastic_buf dut (
        .wr_clk    (wr_clk),
        .wr_rst_n  (wr_rst_n),
        .in_valid  (in_valid),
        .in_block  (in_block),
        .ovf_flag  (ovf_flag),
        .rd_clk    (rd_clk),
        .rd_rst_n  (rd_rst_n),
        .out_valid (out_valid),
        .out_block (out_block),
        .ins_flag  (ins_flag),
        .del_flag  (del_flag),
        .unf_flag  (unf_flag)
    );

    always #10 wr_clk = ~wr_clk;
    initial forever #(rd_half) rd_clk = ~rd_clk;

    task automatic check(input bit ok, input string req,
                         input logic [65:0] act, input logic [65:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Stream monitor, sampled away from the read edge
    always @(negedge rd_clk) begin
        if (rd_rst_n) begin
            if (ins_flag && del_flag)
                check(1'b0, "R9 ins/del together", 66'd1, 66'd0);
            if (ins_flag) n_ins++;
            if (del_flag) n_del++;
            if (out_valid) n_valid++;
            if (chk_en && out_valid) begin
                if (ins_flag) begin
                    check(out_block == last_out && last_out == CC,
                          "R5 repeated block", out_block, CC);
                end else if (del_flag) begin
                    check(q[head] == CC, "R4 skipped block", q[head], CC);
                    check(out_block == q[head+1], "R4 block after skip",
                          out_block, q[head+1]);
                    head += 2;
                end else begin
                    check(head < wcnt && out_block == q[head], "R3 order",
                          out_block, q[head]);
                    head++;
                end
                last_out = out_block;
            end else if (chk_en && (ins_flag || del_flag)) begin
                check(1'b0, "R4/R5 flag without block", 66'd0, 66'd1);
            end
        end
    end

    task automatic push(input int n, input int spacing, input bit bad);
        for (int i = 0; i < n; i++) begin
            logic [65:0] blk;
            @(negedge wr_clk);
            if (spacing != 0 && (wcnt % spacing) == spacing - 1)
                blk = bad ? BAD : CC;
            else
                blk = {2'b10, 32'hDA7A_0000, 32'(wcnt)};
            in_valid = 1'b1;
            in_block = blk;
            q[wcnt]  = blk;
            wcnt++;
        end
        @(negedge wr_clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_rd(input int n);
        repeat (n) @(negedge rd_clk);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL R3 watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        wait_rd(3);
        // R8: reset state
        check(!out_valid && !ins_flag && !del_flag && !unf_flag && !ovf_flag,
              "R8 reset outputs", {61'd0, out_valid, ins_flag, del_flag, unf_flag, ovf_flag}, 66'd0);
        check(out_block == '0, "R8 reset block", out_block, 66'd0);
        @(negedge wr_clk); wr_rst_n = 1'b1;
        @(negedge rd_clk); rd_rst_n = 1'b1;
        chk_en = 1'b1;

        // R2: 39 blocks do not start the read side
        push(39, 0, 0);
        wait_rd(40);
        check(n_valid == 0, "R2 hold-off below 40", 66'(n_valid), 66'd0);

        for (int p = 0; p < NPH; p++) begin
            rd_half = PH[p][0] / 2;
            n_ins = 0;
            n_del = 0;
            push(PH[p][1], PH[p][2], 1'b0);
            wait_rd(4);
            if (PH[p][3] == 0) check(n_ins == 0, "R5 no insert", 66'(n_ins), 66'd0);
            if (PH[p][3] == 1) check(n_ins > 0,  "R5 insert seen", 66'(n_ins), 66'd1);
            if (PH[p][4] == 0) check(n_del == 0, "R4 no delete", 66'(n_del), 66'd0);
            if (PH[p][4] == 1) check(n_del > 0,  "R4 delete seen", 66'(n_del), 66'd1);
        end
        check(n_valid > 0, "R2 reading started", 66'(n_valid), 66'd1);
        check(ovf_flag == 1'b0, "R6 no overflow yet", 66'(ovf_flag), 66'd0);
        check(unf_flag == 1'b0, "R7 no underflow yet", 66'(unf_flag), 66'd0);

        // R1: wrong-header idle blocks while filling past 48
        chk_en = 1'b0;
        rd_half = 11;
        n_del = 0;
        n_ins = 0;
        push(400, 3, 1'b1);
        wait_rd(4);
        check(n_del == 0, "R1 header 10 not deleted", 66'(n_del), 66'd0);
        check(ovf_flag == 1'b1, "R6 overflow sticky", 66'(ovf_flag), 66'd1);

        // R7: drain with no writes
        rd_half = 10;
        wait_rd(200);
        check(unf_flag == 1'b1, "R7 underflow sticky", 66'(unf_flag), 66'd1);
        check(out_valid == 1'b0, "R7 no output when empty", 66'(out_valid), 66'd0);
        check(ovf_flag == 1'b1, "R6 overflow still set", 66'(ovf_flag), 66'd1);

        // R8: reset clears sticky flags
        @(negedge rd_clk);
        wr_rst_n = 1'b0;
        rd_rst_n = 1'b0;
        wait_rd(3);
        check(!ovf_flag && !unf_flag && !out_valid && !ins_flag && !del_flag,
              "R8 flags cleared", {61'd0, ovf_flag, unf_flag, out_valid, ins_flag, del_flag}, 66'd0);
        summary();
    end
endmodule